// File: doc/BRIEF.md
# Power-Down Safe Bus Master Interface

This block sits between a processor core and a shared single-layer system bus. It takes one access at a time from the core: an instruction fetch, a data load or a data store. It runs the request/grant exchange with the bus arbiter, drives the address phase and the data phase, and hands read data back to the core. The processor can stop its core clock to save power. The block therefore takes two clocks. The free-running clock drives all bus-facing logic. The gated core clock drives only the register that captures a command from the core.

Bus ownership is tracked at every free-running edge, including edges during sleep. Ownership means the grant sampled while the ready line was high. Suppose the processor sleeps while it holds the bus, and another master wins the grant on the same edge the processor wakes. The block has already recorded the loss before the core can issue its first access. That access then requests the bus, waits for the grant and completes with the correct word. An arbiter with no pending requests parks the grant on this master. The block makes no assumption about that parking and always checks its recorded ownership first.

Sleep is requested with a one-cycle pulse. It takes effect only once no access is in flight. A wake pulse ends it on the next free-running edge. The block reports its sleep state on an output so that an external gate can stop the core clock.

Top module: `pd_bus_master`

## Requirements
- R1: After synchronous reset the block drives transfer type IDLE (code 2'b00), request low, response valid low and sleep state low, with the core port ready.
- R2: A NONSEQ address phase (code 2'b10) is driven only while the block owns the bus. Ownership is set by the grant being sampled high on a free-running edge where ready was high, and it is held on edges where ready is low.
- R3: While an access is pending and the bus is not owned, the request output is high and the transfer type stays IDLE.
- R4: A load accepted while the bus is owned, with no wait states, gives a one-cycle response valid pulse two free-running edges after the accepting edge. The pulse carries the read data sampled on the edge that ends the data phase.
- R5: Each cycle in which ready is low during the data phase delays the response by one cycle, and the returned word is still the one present when ready rises.
- R6: A store drives the write flag high in its address phase and the store data during its data phase, and ends with a response valid pulse.
- R7: The data-access flag is low in the address phase of an instruction fetch and high for loads and stores. A fetch is always a read, whatever the write input says.
- R8: A sleep request is taken only once no access is in flight. Sleep state rises on the second free-running edge after the request pulse when the block is idle. While asleep the block drives IDLE, keeps its request low and holds the core port not ready.
- R9: A wake pulse clears the sleep state on the next free-running edge.
- R10: If the grant is lost on the wake edge after sleeping while owning the bus, the first load after wake-up waits for the grant and returns the correct memory word.
- R11: The core port is not ready while an accepted access has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_free | input | 1 | Free-running clock; drives all bus-facing logic |
| clk_core | input | 1 | Core clock, stopped while asleep; drives command capture |
| rst | input | 1 | Synchronous active-high reset |
| hgrant | input | 1 | Arbiter grant to this master |
| hready | input | 1 | Bus transfer-done / ready line |
| hrdata | input | DW | Bus read data |
| hbusreq | output | 1 | Bus request to the arbiter |
| htrans | output | 2 | Transfer type: 2'b00 IDLE, 2'b10 NONSEQ |
| haddr | output | AW | Address of the address phase |
| hwrite | output | 1 | High for a store address phase |
| hwdata | output | DW | Store data during the data phase |
| hprot_data | output | 1 | High for a data access, low for a fetch |
| cmd_valid | input | 1 | Core command valid |
| cmd_ready | output | 1 | Block can take a command |
| cmd_fetch | input | 1 | Command is an instruction fetch |
| cmd_write | input | 1 | Command is a store |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | DW | Command store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_valid |
| pd_enter | input | 1 | Sleep request pulse |
| pd_exit | input | 1 | Wake pulse |
| pd_active | output | 1 | Block is asleep; core clock may be gated |

## Verification
The bench counts free-running rising edges from the edge that accepts a command. It expects the response pulse after two of them, plus one more for each cycle it holds ready low. It reads all outputs at the falling edge between rising edges, so it sees registered results only after the edge that produced them. For sleep, it expects the state to rise two edges after an idle request pulse, one edge after a deferred access has completed, and to fall one edge after a wake pulse. Monitors at every falling edge flag any NONSEQ driven without ownership, and any transfer or request while asleep. The monitors track ownership from grant and ready themselves.

// File: rtl/pdsb_pkg.sv
package pdsb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_DATA = 1'b1
    } xstate_e;

    typedef struct packed {
        logic write;
        logic fetch;
    } acc_kind_t;

    function automatic logic [1:0] trans_code(input logic addr_phase);
        return addr_phase ? TR_NONSEQ : TR_IDLE;
    endfunction

    function automatic logic is_data(input acc_kind_t k);
        return !k.fetch;
    endfunction

    function automatic acc_kind_t make_kind(input logic fetch, input logic write);
        acc_kind_t k;
        k.fetch = fetch;
        k.write = write && !fetch;
        return k;
    endfunction

endpackage

// File: rtl/pdsb_cmd_capture.sv
module pdsb_cmd_capture
    import pdsb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk_core,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_fetch,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          block,
    input  logic          done_tog,
    output logic          cmd_ready,
    output logic          pending,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output acc_kind_t     kind_q
);

    logic cmd_tog;

    // an access is outstanding while the two toggles disagree
    assign pending   = cmd_tog ^ done_tog;
    assign cmd_ready = !pending && !block;

    always_ff @(posedge clk_core) begin
        if (rst) begin
            cmd_tog <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            kind_q  <= '0;
        end else if (cmd_valid && cmd_ready) begin
            cmd_tog <= ~cmd_tog;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            kind_q  <= make_kind(cmd_fetch, cmd_write);
        end
    end

    assert_one_outstanding_R11: assert property (@(posedge clk_core) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: rtl/pdsb_bus_track.sv
module pdsb_bus_track (
    input  logic clk_free,
    input  logic rst,
    input  logic hgrant,
    input  logic hready,
    input  logic pd_enter,
    input  logic pd_exit,
    input  logic busy,
    output logic own_q,
    output logic pd_arm,
    output logic pd_active
);

    // ownership of the next address phase, learned on every free-running edge
    always_ff @(posedge clk_free) begin
        if (rst) begin
            own_q <= 1'b0;
        end else if (hready) begin
            own_q <= hgrant;
        end
    end

    always_ff @(posedge clk_free) begin
        if (rst) begin
            pd_arm    <= 1'b0;
            pd_active <= 1'b0;
        end else if (pd_exit) begin
            pd_arm    <= 1'b0;
            pd_active <= 1'b0;
        end else if (pd_arm && !busy) begin
            pd_arm    <= 1'b0;
            pd_active <= 1'b1;
        end else if (pd_enter && !pd_active) begin
            pd_arm    <= 1'b1;
        end
    end

    assert_exit_wakes_R9: assert property (@(posedge clk_free) disable iff (rst)
        pd_exit |=> !pd_active);

    assert_enter_when_idle_R8: assert property (@(posedge clk_free) disable iff (rst)
        (!pd_active && busy) |=> !pd_active);

endmodule

// File: rtl/pdsb_xfer_fsm.sv
module pdsb_xfer_fsm
    import pdsb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk_free,
    input  logic          rst,
    input  logic          pending,
    input  logic          own,
    input  logic          pd_active,
    input  logic          hready,
    input  logic [DW-1:0] hrdata,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  acc_kind_t     kind_q,
    output logic [1:0]    htrans,
    output logic          hbusreq,
    output logic [AW-1:0] haddr,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    output logic          hprot_data,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          done_tog,
    output logic          busy
);

    xstate_e state_q;
    logic    addr_phase;
    logic    in_data;

    assign in_data    = (state_q == XS_DATA);
    assign addr_phase = !in_data && pending && own && !pd_active;

    assign htrans     = trans_code(addr_phase);
    assign hbusreq    = !in_data && pending && !pd_active;
    assign haddr      = addr_phase ? addr_q : '0;
    assign hwrite     = addr_phase && kind_q.write;
    assign hprot_data = addr_phase && is_data(kind_q);
    assign hwdata     = (in_data && kind_q.write) ? wdata_q : '0;
    assign busy       = pending || in_data;

    always_ff @(posedge clk_free) begin
        if (rst) begin
            state_q   <= XS_IDLE;
            done_tog  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    if (addr_phase && hready) begin
                        state_q <= XS_DATA;
                    end
                end
                XS_DATA: begin
                    if (hready) begin
                        state_q   <= XS_IDLE;
                        done_tog  <= ~done_tog;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= kind_q.write ? '0 : hrdata;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assert_addr_owned_R2: assert property (@(posedge clk_free) disable iff (rst)
        (htrans == 2'b10) |-> own);

    assert_request_unowned_R3: assert property (@(posedge clk_free) disable iff (rst)
        (pending && !own && !pd_active && !in_data) |-> (hbusreq && htrans == 2'b00));

    assert_rsp_pulse_R4: assert property (@(posedge clk_free) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_wait_hold_R5: assert property (@(posedge clk_free) disable iff (rst)
        (in_data && !hready) |=> (in_data && !rsp_valid));

endmodule

// File: rtl/pd_bus_master.sv
module pd_bus_master
    import pdsb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk_free,
    input  logic          clk_core,
    input  logic          rst,
    input  logic          hgrant,
    input  logic          hready,
    input  logic [DW-1:0] hrdata,
    output logic          hbusreq,
    output logic [1:0]    htrans,
    output logic [AW-1:0] haddr,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    output logic          hprot_data,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_fetch,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          pd_enter,
    input  logic          pd_exit,
    output logic          pd_active
);

    logic          pending;
    logic          done_tog;
    logic          own_q;
    logic          pd_arm;
    logic          busy;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    acc_kind_t     kind_q;

    pdsb_cmd_capture #(.AW(AW), .DW(DW)) u_capture (
        .clk_core  (clk_core),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_fetch (cmd_fetch),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .block     (pd_arm || pd_active),
        .done_tog  (done_tog),
        .cmd_ready (cmd_ready),
        .pending   (pending),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .kind_q    (kind_q)
    );

    pdsb_bus_track u_track (
        .clk_free  (clk_free),
        .rst       (rst),
        .hgrant    (hgrant),
        .hready    (hready),
        .pd_enter  (pd_enter),
        .pd_exit   (pd_exit),
        .busy      (busy),
        .own_q     (own_q),
        .pd_arm    (pd_arm),
        .pd_active (pd_active)
    );

    pdsb_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk_free   (clk_free),
        .rst        (rst),
        .pending    (pending),
        .own        (own_q),
        .pd_active  (pd_active),
        .hready     (hready),
        .hrdata     (hrdata),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .kind_q     (kind_q),
        .htrans     (htrans),
        .hbusreq    (hbusreq),
        .haddr      (haddr),
        .hwrite     (hwrite),
        .hwdata     (hwdata),
        .hprot_data (hprot_data),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .done_tog   (done_tog),
        .busy       (busy)
    );

    assert_sleep_quiet_R8: assert property (@(posedge clk_free) disable iff (rst)
        pd_active |-> (htrans == 2'b00 && !hbusreq && !cmd_ready));

endmodule

// File: tb/pd_bus_master_tb.sv
module pd_bus_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          core_en = 1'b1;
    logic          clk_core;
    logic          rst;
    logic          hgrant, hready;
    logic [DW-1:0] hrdata;
    logic          hbusreq, hwrite, hprot_data;
    logic [1:0]    htrans;
    logic [AW-1:0] haddr;
    logic [DW-1:0] hwdata;
    logic          cmd_valid, cmd_ready, cmd_fetch, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          pd_enter, pd_exit, pd_active;

    int errors = 0;
    int checks = 0;
    int own_viol = 0;
    int sleep_viol = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign clk_core = clk & core_en;

    pd_bus_master #(.AW(AW), .DW(DW)) u_dut (
        .clk_free(clk), .clk_core(clk_core), .rst(rst),
        .hgrant(hgrant), .hready(hready), .hrdata(hrdata),
        .hbusreq(hbusreq), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
        .hwdata(hwdata), .hprot_data(hprot_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fetch(cmd_fetch),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pd_enter(pd_enter), .pd_exit(pd_exit), .pd_active(pd_active)
    );

    // clock gate: enable changes only while clk is low
    always @(negedge clk) core_en <= rst ? 1'b1 : !pd_active;

    function automatic logic [31:0] init_word(input int i);
        return 32'hC0DE_0000 + i * 32'h0000_1111;
    endfunction

    // bench memory slave and independent ownership record
    logic [31:0] mem [16];
    logic [31:0] ref_mem [16];
    logic        bench_own;
    logic        dp_valid, dp_write;
    logic [3:0]  dp_idx;

    assign hrdata = dp_valid ? mem[dp_idx] : 32'h0;

    always @(posedge clk) begin
        if (rst) begin
            bench_own <= 1'b0;
            dp_valid  <= 1'b0;
            dp_write  <= 1'b0;
            dp_idx    <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
        end else if (hready) begin
            bench_own <= hgrant;
            if (dp_valid && dp_write) mem[dp_idx] <= hwdata;
            dp_valid <= (htrans == 2'b10) && bench_own;
            dp_write <= hwrite;
            dp_idx   <= haddr[5:2];
        end
    end

    logic last_prot, last_write;
    always @(negedge clk) begin
        if (!rst) begin
            if (htrans == 2'b10) begin
                last_prot  <= hprot_data;
                last_write <= hwrite;
                if (!bench_own) own_viol++;
            end
            if (pd_active && (htrans != 2'b00 || hbusreq || cmd_ready)) sleep_viol++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_access(input bit fetch, input bit write, input logic [31:0] addr,
                             input logic [31:0] wdata, input int stall,
                             output logic [31:0] rdata, output int lat);
        @(negedge clk);
        cmd_fetch = fetch; cmd_write = write; cmd_addr = addr; cmd_wdata = wdata;
        cmd_valid = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R11", "ready while pending", {31'b0, cmd_ready}, 0);
        while (!rsp_valid && lat < 40) begin
            if (stall > 0 && lat == 1) hready = 1'b0;
            if (stall > 0 && lat == 1 + stall) hready = 1'b1;
            @(posedge clk); lat++; @(negedge clk);
        end
        rdata = rsp_rdata;
        if (write && !fetch) ref_mem[addr[5:2]] = wdata;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4", "response pulse width", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_reset;
        chk(htrans == 2'b00, "R1", "reset htrans", {30'b0, htrans}, 0);
        chk(!hbusreq && !rsp_valid && !pd_active, "R1", "reset req/rsp/pd",
            {29'b0, hbusreq, rsp_valid, pd_active}, 0);
        chk(cmd_ready == 1'b1, "R1", "reset ready", {31'b0, cmd_ready}, 1);
    endtask

    task automatic t_load_basic;
        logic [31:0] d; int lat;
        do_access(1'b0, 1'b0, 32'h0000_0008, 0, 0, d, lat);
        chk(lat == 2, "R4", "load latency", lat, 2);
        chk(d == ref_mem[2], "R4", "load data", d, ref_mem[2]);
        chk(last_prot == 1'b1, "R7", "load data flag", {31'b0, last_prot}, 1);
    endtask

    task automatic t_fetch;
        logic [31:0] d; int lat;
        do_access(1'b1, 1'b1, 32'h0000_0030, 32'hDEAD_BEEF, 0, d, lat);
        chk(d == ref_mem[12], "R7", "fetch data", d, ref_mem[12]);
        chk(last_prot == 1'b0, "R7", "fetch data flag", {31'b0, last_prot}, 0);
        chk(last_write == 1'b0, "R7", "fetch never writes", {31'b0, last_write}, 0);
    endtask

    task automatic t_store;
        logic [31:0] d; int lat;
        do_access(1'b0, 1'b1, 32'h0000_0014, 32'h1234_5678, 0, d, lat);
        chk(lat == 2, "R6", "store response", lat, 2);
        chk(last_write == 1'b1, "R6", "store write flag", {31'b0, last_write}, 1);
        do_access(1'b0, 1'b0, 32'h0000_0014, 0, 0, d, lat);
        chk(d == 32'h1234_5678, "R6", "store readback", d, 32'h1234_5678);
    endtask

    task automatic t_wait_states;
        logic [31:0] d; int lat;
        do_access(1'b0, 1'b0, 32'h0000_0024, 0, 3, d, lat);
        chk(lat == 5, "R5", "latency with 3 wait cycles", lat, 5);
        chk(d == ref_mem[9], "R5", "data after wait", d, ref_mem[9]);
    endtask

    task automatic t_sleep_deferred;
        // accept a load, then request sleep while it is in flight
        @(negedge clk);
        cmd_fetch = 1'b0; cmd_write = 1'b0; cmd_addr = 32'h0000_000C; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; pd_enter = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pd_enter = 1'b0;
        chk(pd_active == 1'b0, "R8", "no sleep mid-access", {31'b0, pd_active}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && pd_active == 1'b0, "R8", "rsp before sleep",
            {30'b0, rsp_valid, pd_active}, 2);
        chk(rsp_rdata == ref_mem[3], "R8", "deferred load data", rsp_rdata, ref_mem[3]);
        @(posedge clk);
        @(negedge clk);
        chk(pd_active == 1'b1, "R8", "sleep after completion", {31'b0, pd_active}, 1);
        @(negedge clk);
        pd_exit = 1'b1;
        @(negedge clk);
        pd_exit = 1'b0;
        chk(pd_active == 1'b0, "R9", "wake clears sleep", {31'b0, pd_active}, 0);
    endtask

    task automatic t_wake_grant_lost;
        logic [31:0] d; int lat;
        @(negedge clk);
        hgrant = 1'b1; pd_enter = 1'b1;
        @(negedge clk);
        pd_enter = 1'b0;
        @(negedge clk);
        chk(pd_active == 1'b1, "R8", "idle sleep two edges", {31'b0, pd_active}, 1);
        repeat (4) @(negedge clk);
        chk(htrans == 2'b00 && !hbusreq && !cmd_ready, "R8", "quiet while asleep",
            {29'b0, htrans, hbusreq}, 0);
        // wake and lose the grant on the same edge
        pd_exit = 1'b1; hgrant = 1'b0;
        @(negedge clk);
        pd_exit = 1'b0;
        chk(pd_active == 1'b0, "R9", "wake edge", {31'b0, pd_active}, 0);
        cmd_fetch = 1'b0; cmd_write = 1'b0; cmd_addr = 32'h0000_0018; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) begin
            chk(hbusreq && htrans == 2'b00, "R3", "request without grant",
                {29'b0, hbusreq, htrans}, 32'h4);
            @(negedge clk);
        end
        hgrant = 1'b1;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk); lat++;
        end
        d = rsp_rdata;
        chk(rsp_valid == 1'b1, "R10", "first load after wake completes", {31'b0, rsp_valid}, 1);
        chk(d == ref_mem[6], "R10", "first load after wake data", d, ref_mem[6]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
        rst = 1'b1; hgrant = 1'b1; hready = 1'b1;
        cmd_valid = 1'b0; cmd_fetch = 1'b0; cmd_write = 1'b0;
        cmd_addr = '0; cmd_wdata = '0; pd_enter = 1'b0; pd_exit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_basic();
        t_fetch();
        t_store();
        t_wait_states();
        t_sleep_deferred();
        t_wake_grant_lost();
        repeat (2) @(negedge clk);
        chk(own_viol == 0, "R2", "NONSEQ without ownership", own_viol, 0);
        chk(sleep_viol == 0, "R8", "activity while asleep", sleep_viol, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule